// File: doc/BRIEF.md
# Timer Count-Enable Generator with Shared Prescaler

This block produces the count-enable pulses for several timer channels. All channels share one free-running 10-bit prescaler counter that advances on every system clock. Each channel has its own 3-bit source-select field, and that field alone decides when the channel's enable pulses. The choices are: stopped, every system clock, one of four prescaler divisions, or one edge polarity of an external pin. The pin is brought into the clock domain and edge-detected before use. Every output is a single-cycle enable in the system clock domain. No output is a derived clock.

The prescaler does not depend on any channel's select field. Selecting a divided source therefore lands the channel on a phase grid that already exists, so the first pulse can come at any point in the divide period. A synchronous prescaler-clear input restarts that grid. The clear affects every channel that uses a divided source at the same time.

The asynchronous active-low reset is released synchronously inside the block, two clock edges after the reset pin rises.

Top module: `tmr_ce_gen`

## Requirements
- R1: A channel whose select code is 0 never asserts its enable.
- R2: A channel whose select code is 1 asserts its enable on every system clock cycle.
- R3: Select codes 2, 3, 4 and 5 give one single-cycle enable every 8, 64, 256 and 1024 cycles respectively. The pulse falls in the cycles where the low 3, 6, 8 or 10 bits of the shared counter are all ones.
- R4: The shared counter keeps running while any channel changes its select code. A channel that leaves a divided source and later returns to it pulses on the same phase grid as before.
- R5: When the prescaler clear is sampled high at a clock edge, the counter reads zero in the following cycle. Every channel on divisor N then pulses first in cycle N-1 after that edge, counting that cycle as cycle 0.
- R6: Each channel applies its own select code independently, and different channels may use different codes in the same cycle.
- R7: With code 7, each rising edge of the external pin gives exactly one enable pulse. The pulse appears in the second clock cycle after the first rising clock edge that follows the pin change.
- R8: With code 6, each falling edge of the external pin gives exactly one enable pulse, with the same latency as R7.
- R9: A pin edge of the polarity a channel did not select produces no enable on that channel.
- R10: While the reset pin is low, all enables stay low for any select code other than 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| presc_clr | input | 1 | Synchronous clear of the shared prescaler counter |
| ext_pin | input | 1 | External count pin, asynchronous to clk |
| chan_sel | input | 3*NCH | Source-select field for each channel; channel i uses bits [3i+2:3i] |
| cnt_en | output | NCH | Single-cycle count enable for each channel |

## Verification
The hardest case is a channel that switches sources while other channels keep running on the shared grid. Its pulses must resume in phase with the grid, and the other channels must not shift. The bench clears the prescaler so that every later cycle has a known index. It then stops channel 0 and restarts it on a divided source while channel 2's code changes every cycle. Every cycle is compared with the expected pattern computed from that index. The pin tests drive a change just after a rising edge and sample the next five cycles, which places each pulse exactly in time.

// File: rtl/tmr_ce_pkg.sv
package tmr_ce_pkg;

  localparam int NTAP = 4;

  typedef enum logic [2:0] {
    SEL_OFF      = 3'd0,
    SEL_SYS      = 3'd1,
    SEL_DIV8     = 3'd2,
    SEL_DIV64    = 3'd3,
    SEL_DIV256   = 3'd4,
    SEL_DIV1024  = 3'd5,
    SEL_PIN_FALL = 3'd6,
    SEL_PIN_RISE = 3'd7
  } src_sel_e;

  // Number of low counter bits that set the period of each tap.
  function automatic int tap_bits(input int idx);
    case (idx)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction

  localparam int CNT_W = tap_bits(NTAP - 1);

endpackage

// File: rtl/tmr_ce_rst_sync.sv
module tmr_ce_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/tmr_ce_presc.sv
module tmr_ce_presc
  import tmr_ce_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  output logic [NTAP-1:0] tap
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    localparam int B = tap_bits(i);
    assign tap[i] = &cnt_q[B-1:0];
  end

  // R5: the cycle after a clear holds a zero count, so no tap fires
  a_r5_clr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (tap == '0));

  // R3: the shortest tap never fires in two cycles in a row
  a_r3_tap_single: assert property (@(posedge clk) disable iff (!rst_n)
    tap[0] |=> !tap[0]);

  for (genvar j = 1; j < NTAP; j++) begin : g_nest
    // R3: a longer period is a multiple of the shorter one
    a_r3_tap_nest: assert property (@(posedge clk) disable iff (!rst_n)
      tap[j] |-> tap[j-1]);
  end
endmodule

// File: rtl/tmr_ce_pin_edge.sv
module tmr_ce_pin_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic lat_q;
  logic sync_q;
  logic prev_q;
  logic rise_q, rise_d;
  logic fall_q, fall_d;

  // Captured while the clock is high, held from its falling edge.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= 1'b0;
    else        lat_q <= pin;
  end

  always_comb begin
    rise_d = sync_q & ~prev_q;
    fall_d = ~sync_q & prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      prev_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      sync_q <= lat_q;
      prev_q <= sync_q;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign rise = rise_q;
  assign fall = fall_q;

  // R9: one sampled transition has a single polarity
  a_r9_one_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_q && fall_q));

  // R7: a rising pulse lasts one cycle
  a_r7_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |=> !rise_q);

  // R8: a falling pulse lasts one cycle
  a_r8_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q |=> !fall_q);
endmodule

// File: rtl/tmr_ce_chan.sv
module tmr_ce_chan
  import tmr_ce_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      sel,
  input  logic [NTAP-1:0] tap,
  input  logic            rise,
  input  logic            fall,
  output logic            en
);
  always_comb begin
    case (sel)
      SEL_OFF:      en = 1'b0;
      SEL_SYS:      en = 1'b1;
      SEL_DIV8:     en = tap[0];
      SEL_DIV64:    en = tap[1];
      SEL_DIV256:   en = tap[2];
      SEL_DIV1024:  en = tap[3];
      SEL_PIN_FALL: en = fall;
      default:      en = rise;
    endcase
  end

  // R1: a stopped channel stays silent
  a_r1_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_OFF) |-> !en);

  // R3: divide-by-8 never gives back-to-back enables
  a_r3_div8_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel == SEL_DIV8) && en) |=> !tap[0]);
endmodule

// File: rtl/tmr_ce_gen.sv
module tmr_ce_gen
  import tmr_ce_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             presc_clr,
  input  logic             ext_pin,
  input  logic [3*NCH-1:0] chan_sel,
  output logic [NCH-1:0]   cnt_en
);
  logic            rst_n_int;
  logic [NTAP-1:0] tap;
  logic            pin_rise;
  logic            pin_fall;

  tmr_ce_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  tmr_ce_presc #(.W(CNT_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_n_int),
    .clr   (presc_clr),
    .tap   (tap)
  );

  tmr_ce_pin_edge u_pin (
    .clk   (clk),
    .rst_n (rst_n_int),
    .pin   (ext_pin),
    .rise  (pin_rise),
    .fall  (pin_fall)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tmr_ce_chan u_chan (
      .clk   (clk),
      .rst_n (rst_n_int),
      .sel   (chan_sel[3*c +: 3]),
      .tap   (tap),
      .rise  (pin_rise),
      .fall  (pin_fall),
      .en    (cnt_en[c])
    );

    // R2: the system-clock source enables every cycle
    a_r2_sys_every: assert property (@(posedge clk) disable iff (!rst_n_int)
      (chan_sel[3*c +: 3] == 3'd1) |-> cnt_en[c]);
  end
endmodule

// File: tb/tmr_ce_gen_tb.sv
module tmr_ce_gen_tb;
  localparam int NCH = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             presc_clr;
  logic             ext_pin;
  logic [3*NCH-1:0] chan_sel;
  logic [NCH-1:0]   cnt_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  tmr_ce_gen #(.NCH(NCH)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .presc_clr (presc_clr),
    .ext_pin   (ext_pin),
    .chan_sel  (chan_sel),
    .cnt_en    (cnt_en)
  );

  task automatic check(input bit act, input bit exp, input string req, input int cyc);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0b expected %0b", req, cyc, act, exp);
    end
  endtask

  task automatic set_sel(input int ch, input logic [2:0] code);
    chan_sel[3*ch +: 3] = code;
  endtask

  // Clears the prescaler; on return, the current negedge is cycle 0 after the clear
  task automatic do_clr();
    @(negedge clk);
    presc_clr = 1'b1;
    @(negedge clk);
    presc_clr = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; presc_clr = 1'b0; ext_pin = 1'b0;
    set_sel(0, 3'd2); set_sel(1, 3'd3); set_sel(2, 3'd0);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) check(cnt_en[c], 1'b0, "R10", i);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_off_sys();
    @(negedge clk);
    set_sel(0, 3'd0); set_sel(1, 3'd1); set_sel(2, 3'd0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check(cnt_en[0], 1'b0, "R1", i);
      check(cnt_en[1], 1'b1, "R2", i);
      check(cnt_en[2], 1'b0, "R1", i);
    end
  endtask

  task automatic t_taps();
    set_sel(0, 3'd2); set_sel(1, 3'd3); set_sel(2, 3'd4);
    do_clr();
    for (int k = 0; k < 600; k++) begin
      check(cnt_en[0], (k % 8)   == 7,   "R3/R5/R6 div8",   k);
      check(cnt_en[1], (k % 64)  == 63,  "R3/R5/R6 div64",  k);
      check(cnt_en[2], (k % 256) == 255, "R3/R5/R6 div256", k);
      @(negedge clk);
    end
    set_sel(0, 3'd5); set_sel(1, 3'd0); set_sel(2, 3'd1);
    do_clr();
    for (int k = 0; k < 2100; k++) begin
      check(cnt_en[0], (k % 1024) == 1023, "R3 div1024", k);
      check(cnt_en[1], 1'b0, "R6", k);
      check(cnt_en[2], 1'b1, "R6", k);
      @(negedge clk);
    end
  endtask

  task automatic t_switch();
    set_sel(0, 3'd2); set_sel(1, 3'd3); set_sel(2, 3'd1);
    do_clr();
    for (int k = 0; k < 200; k++) begin
      bit on;
      on = (k < 20) || (k >= 35);
      check(cnt_en[0], on && ((k % 8) == 7), "R4 ch0 regrid", k);
      check(cnt_en[1], (k % 64) == 63, "R4 ch1 undisturbed", k);
      set_sel(0, ((k + 1) >= 20 && (k + 1) < 35) ? 3'd0 : 3'd2);
      set_sel(2, 3'(k % 6));
      @(negedge clk);
    end
  endtask

  task automatic pin_step(input logic v, input bit exp_fall, input bit exp_rise, input string req);
    @(posedge clk);
    #1 ext_pin = v;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(cnt_en[0], exp_fall && (i == 2), req, i);
      check(cnt_en[1], exp_rise && (i == 2), req, i);
    end
  endtask

  task automatic t_pin();
    @(negedge clk);
    set_sel(0, 3'd6); set_sel(1, 3'd7); set_sel(2, 3'd0);
    repeat (3) @(negedge clk);
    for (int r = 0; r < 3; r++) begin
      pin_step(1'b1, 1'b0, 1'b1, "R7/R9 rising");
      pin_step(1'b0, 1'b1, 1'b0, "R8/R9 falling");
    end
  endtask

  initial begin
    t_reset();
    t_off_sys();
    t_taps();
    t_switch();
    t_pin();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule